// File: doc/BRIEF.md
# Receive Buffer Pause Watermark Controller

This block watches the occupancy of one port's receive buffer and asks a separate flow-control frame generator to send pause frames. Each write strobe adds one 8-byte word to a running occupancy count and each read strobe removes one. The default capacity of 2176 words equals 17 KB. When occupancy climbs to the high threshold, the block asks for a frame that stops the link partner. That frame carries a programmable, nonzero quanta. Once a stop has been asked for, no further stop is asked for until occupancy sinks below the low threshold. At that point the block asks for a frame with quanta zero, which lets the partner send again.

Requests leave on a valid/ready channel. `pf_valid` stays high and `pf_quanta` stays unchanged until the generator asserts `pf_ready` with `pf_valid` high on a rising clock edge. That edge is the transfer, and the generator may hold `pf_ready` low for as long as it likes. There is one exception to this rule. A stop request that has not yet been taken is withdrawn if the resume condition arises first. Automatic generation is on after reset and can be switched through a one-bit register write.

Top module: `rxq_pause_ctrl`

## Requirements
- R1: `fill_level` rises by one on a cycle with `wr_en` and no `rd_en`, and falls by one on a cycle with `rd_en` and no `wr_en`. A write at `DEPTH` (default 2176) is ignored and a read at zero is ignored. When both strobes are high and the count is strictly between zero and `DEPTH`, it is unchanged.
- R2: The auto-generation enable is 1 after reset. On a cycle with `en_we` high it takes `en_wdata`.
- R3: The block is enabled, the settings are valid and no stop is outstanding. If `fill_level >= cfg_high` at one clock edge, `pf_valid` rises at the next edge with `pf_quanta = cfg_quanta`, and `link_paused` becomes 1.
- R4: While `link_paused` is 1, no further stop request is issued, however much more data arrives.
- R5: If `link_paused` is 1 and `fill_level < cfg_low`, one resume request with `pf_quanta = 0` is issued and `link_paused` clears. No resume request is issued without a prior stop.
- R6: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` and `pf_quanta` hold. The only exception is the withdrawal in R7.
- R7: Suppose a stop request is still waiting (no `pf_ready`) when the resume condition of R5 or R8 arises. The request is withdrawn: `pf_valid` falls, `link_paused` clears, and no resume request follows.
- R8: Clearing the enable while `link_paused` is 1 issues exactly one resume request and clears `link_paused`. While disabled, no stop request is issued.
- R9: Settings are valid only when `cfg_high > cfg_low` and `cfg_quanta != 0`. With invalid settings no stop request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One word stored into the buffer |
| rd_en | input | 1 | One word removed from the buffer |
| cfg_high | input | FILL_W (12) | Stop threshold in words |
| cfg_low | input | FILL_W (12) | Resume threshold in words |
| cfg_quanta | input | Q_W (16) | Quanta for stop requests |
| en_we | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| pf_valid | output | 1 | Frame request valid |
| pf_ready | input | 1 | Generator accepts the request |
| pf_quanta | output | Q_W (16) | Quanta of the request (0 = resume) |
| fill_level | output | FILL_W (12) | Current occupancy in words |
| link_paused | output | 1 | A stop has been issued and not yet undone |

## Verification
The hardest case to reach is the withdrawal of R7. It needs a stop request left waiting while the buffer drains past the low threshold. The bench holds `pf_ready` low, fills to the high mark, then reads down below the low mark before releasing `pf_ready`. It then confirms that the request vanished and that no resume frame appears. The disable-while-paused path and a fill to full capacity are driven the same way: through long strobe bursts, with every handshake compared against an expected queue.

// File: rtl/rxq_pause_pkg.sv
package rxq_pause_pkg;
  typedef enum logic {REQ_RESUME = 1'b0, REQ_STOP = 1'b1} req_kind_e;
endpackage

// File: rtl/rxq_fill_tracker.sv
module rxq_fill_tracker #(
  parameter int DEPTH  = 2176,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [FILL_W-1:0] fill
);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

  logic do_wr, do_rd;
  assign do_wr = wr_en && (fill != FULL);
  assign do_rd = rd_en && (fill != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) fill <= '0;
    else if (do_wr && !do_rd) fill <= fill + 1'b1;
    else if (do_rd && !do_wr) fill <= fill - 1'b1;
  end

  // R1: occupancy never exceeds capacity
  p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL);
  // R1: occupancy moves by at most one word per cycle
  p_fill_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == $past(fill)) || (fill == $past(fill) + 1'b1) || (fill == $past(fill) - 1'b1));
endmodule

// File: rtl/rxq_wm_compare.sv
module rxq_wm_compare #(
  parameter int FILL_W = 12,
  parameter int Q_W    = 16
) (
  input  logic [FILL_W-1:0] fill,
  input  logic [FILL_W-1:0] cfg_high,
  input  logic [FILL_W-1:0] cfg_low,
  input  logic [Q_W-1:0]    cfg_quanta,
  output logic              at_high,
  output logic              below_low,
  output logic              cfg_ok
);
  always_comb begin
    at_high   = fill >= cfg_high;
    below_low = fill < cfg_low;
    cfg_ok    = (cfg_high > cfg_low) && (cfg_quanta != '0);
  end

  // R9: a valid setting always separates the two thresholds
  a_thresh_r9: assert final (!cfg_ok || !(at_high && below_low));
endmodule

// File: rtl/rxq_pause_fsm.sv
module rxq_pause_fsm
  import rxq_pause_pkg::*;
#(
  parameter int Q_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           at_high,
  input  logic           below_low,
  input  logic           cfg_ok,
  input  logic [Q_W-1:0] cfg_quanta,
  input  logic           en_we,
  input  logic           en_wdata,
  input  logic           pf_ready,
  output logic           pf_valid,
  output logic [Q_W-1:0] pf_quanta,
  output logic           paused
);
  logic      en;
  logic      pend;
  req_kind_e kind;
  logic      accept, slot_free, stop_go, resume_go, withdraw;

  always_comb begin
    accept    = pend && pf_ready;
    slot_free = !pend || accept;
    stop_go   = en && cfg_ok && at_high && !paused;
    resume_go = paused && (!en || (cfg_ok && below_low));
    withdraw  = resume_go && pend && (kind == REQ_STOP) && !pf_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b1;
      pend      <= 1'b0;
      kind      <= REQ_RESUME;
      pf_quanta <= '0;
      paused    <= 1'b0;
    end else begin
      if (en_we) en <= en_wdata;
      if (accept) pend <= 1'b0;
      if (resume_go) begin
        if (withdraw) begin
          pend   <= 1'b0;
          paused <= 1'b0;
        end else if (slot_free) begin
          pend      <= 1'b1;
          kind      <= REQ_RESUME;
          pf_quanta <= '0;
          paused    <= 1'b0;
        end
      end else if (stop_go && slot_free) begin
        pend      <= 1'b1;
        kind      <= REQ_STOP;
        pf_quanta <= cfg_quanta;
        paused    <= 1'b1;
      end
    end
  end

  assign pf_valid = pend;

  // R6: a waiting resume request is never dropped or altered
  p_resume_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && pf_quanta == '0) |=> (pf_valid && pf_quanta == '0));
  // R6: a waiting request keeps its payload unless withdrawn
  p_payload_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (!pf_valid || $stable(pf_quanta)));
  // R3/R5: stop requests carry nonzero quanta while paused, resume carries zero
  p_kind_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (paused == (pf_quanta != '0)));
  // R5: a fresh resume request only follows a paused state
  p_resume_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pf_valid) && pf_quanta == '0) |-> $past(paused));
  // R8/R9: pausing requires enable and valid settings
  p_pause_needs_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> $past(en && cfg_ok && at_high));
endmodule

// File: rtl/rxq_pause_ctrl.sv
module rxq_pause_ctrl #(
  parameter int DEPTH  = 2176,
  parameter int Q_W    = 16,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [FILL_W-1:0] cfg_high,
  input  logic [FILL_W-1:0] cfg_low,
  input  logic [Q_W-1:0]    cfg_quanta,
  input  logic              en_we,
  input  logic              en_wdata,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [Q_W-1:0]    pf_quanta,
  output logic [FILL_W-1:0] fill_level,
  output logic              link_paused
);
  logic at_high, below_low, cfg_ok;

  rxq_fill_tracker #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .fill(fill_level)
  );

  rxq_wm_compare #(.FILL_W(FILL_W), .Q_W(Q_W)) u_cmp (
    .fill(fill_level), .cfg_high(cfg_high), .cfg_low(cfg_low),
    .cfg_quanta(cfg_quanta), .at_high(at_high), .below_low(below_low),
    .cfg_ok(cfg_ok)
  );

  rxq_pause_fsm #(.Q_W(Q_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .at_high(at_high), .below_low(below_low),
    .cfg_ok(cfg_ok), .cfg_quanta(cfg_quanta), .en_we(en_we),
    .en_wdata(en_wdata), .pf_ready(pf_ready), .pf_valid(pf_valid),
    .pf_quanta(pf_quanta), .paused(link_paused)
  );
endmodule

// File: tb/rxq_pause_ctrl_tb.sv
module rxq_pause_ctrl_tb;
  localparam int DEPTH  = 2176;
  localparam int Q_W    = 16;
  localparam int FILL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [FILL_W-1:0] cfg_high = 20, cfg_low = 10;
  logic [Q_W-1:0] cfg_quanta = 16'h0100;
  logic en_we = 1'b0, en_wdata = 1'b0;
  logic pf_valid, pf_ready = 1'b1;
  logic [Q_W-1:0] pf_quanta;
  logic [FILL_W-1:0] fill_level;
  logic link_paused;

  int n_run = 0, n_fail = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  rxq_pause_ctrl #(.DEPTH(DEPTH), .Q_W(Q_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_quanta(cfg_quanta),
    .en_we(en_we), .en_wdata(en_wdata), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_quanta(pf_quanta), .fill_level(fill_level),
    .link_paused(link_paused)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: every accepted request is compared against the scoreboard
  always @(negedge clk) begin
    if (rst_n && pf_valid && pf_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R4/R5/R7 unexpected request", int'(pf_quanta), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(pf_quanta) == e, "R3/R5 request quanta", int'(pf_quanta), e);
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask
  task automatic wr_n(input int n);
    for (int i = 0; i < n; i++) begin wr_en = 1'b1; @(posedge clk); #1; end
    wr_en = 1'b0;
  endtask
  task automatic rd_n(input int n);
    for (int i = 0; i < n; i++) begin rd_en = 1'b1; @(posedge clk); #1; end
    rd_en = 1'b0;
  endtask
  task automatic set_en(input bit v);
    en_we = 1'b1; en_wdata = v; @(posedge clk); #1; en_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    chk(fill_level == 0, "R1 reset fill", int'(fill_level), 0);
    chk(!pf_valid, "R3 reset valid", int'(pf_valid), 0);
    chk(!link_paused, "R4 reset paused", int'(link_paused), 0);

    // R2 + R3: enable on after reset, stop at high mark
    exp_q.push_back(16'h0100);
    wr_n(19); cyc(3);
    chk(!link_paused, "R3 below high no pause", int'(link_paused), 0);
    wr_n(1); cyc(3);
    chk(link_paused, "R2 R3 paused at high", int'(link_paused), 1);
    chk(fill_level == 20, "R1 fill count", int'(fill_level), 20);

    // R4: extra data while paused, no second stop
    wr_n(5); rd_n(5); cyc(3);
    // R5: resume below low
    exp_q.push_back(0);
    rd_n(10); cyc(3);
    chk(link_paused, "R5 not yet below low", int'(link_paused), 1);
    rd_n(1); cyc(3);
    chk(!link_paused, "R5 paused cleared", int'(link_paused), 0);

    // R6: held request
    pf_ready = 1'b0;
    wr_n(11); cyc(3);
    for (int i = 0; i < 4; i++) begin
      chk(pf_valid && pf_quanta == 16'h0100, "R6 request held", int'(pf_quanta), 16'h0100);
      cyc(1);
    end
    exp_q.push_back(16'h0100);
    pf_ready = 1'b1; cyc(3);

    // R7: withdrawal of a waiting stop
    exp_q.push_back(0);
    rd_n(11); cyc(3);
    pf_ready = 1'b0;
    wr_n(11); cyc(2);
    chk(pf_valid, "R7 stop waiting", int'(pf_valid), 1);
    rd_n(11); cyc(2);
    chk(!pf_valid, "R7 stop withdrawn", int'(pf_valid), 0);
    chk(!link_paused, "R7 paused cleared", int'(link_paused), 0);
    pf_ready = 1'b1; cyc(4);

    // R8: disable while paused
    exp_q.push_back(16'h0100);
    wr_n(11); cyc(3);
    exp_q.push_back(0);
    set_en(1'b0); cyc(3);
    chk(!link_paused, "R8 disable clears pause", int'(link_paused), 0);
    wr_n(3); cyc(4);
    chk(!link_paused, "R8 no stop while disabled", int'(link_paused), 0);

    // R2: re-enable, stop at once since fill 23 >= 20
    exp_q.push_back(16'h0100);
    set_en(1'b1); cyc(3);
    chk(link_paused, "R2 re-enable stops", int'(link_paused), 1);
    exp_q.push_back(0);
    rd_n(23); cyc(3);
    chk(fill_level == 0, "R1 drained", int'(fill_level), 0);

    // R9: invalid settings
    cfg_high = 10; cfg_low = 10;
    wr_n(15); cyc(3);
    chk(!link_paused, "R9 high==low ignored", int'(link_paused), 0);
    wr_en = 1'b1; rd_en = 1'b1; cyc(3); wr_en = 1'b0; rd_en = 1'b0;
    chk(fill_level == 15, "R1 simultaneous strobes", int'(fill_level), 15);
    cfg_high = 12; cfg_low = 5; cfg_quanta = 0; cyc(4);
    chk(!link_paused, "R9 zero quanta ignored", int'(link_paused), 0);
    exp_q.push_back(16'h0040);
    cfg_quanta = 16'h0040; cyc(3);
    chk(link_paused, "R9 valid settings stop", int'(link_paused), 1);
    exp_q.push_back(0);
    rd_n(15); cyc(3);

    // R1: capacity limits
    exp_q.push_back(16'h0040);
    wr_n(DEPTH + 3); cyc(2);
    chk(fill_level == DEPTH, "R1 full saturates", int'(fill_level), DEPTH);
    wr_en = 1'b1; rd_en = 1'b1; cyc(1); wr_en = 1'b0; rd_en = 1'b0;
    chk(fill_level == DEPTH - 1, "R1 write at full ignored", int'(fill_level), DEPTH - 1);
    exp_q.push_back(0);
    rd_n(DEPTH + 2); cyc(3);
    chk(fill_level == 0, "R1 read at empty ignored", int'(fill_level), 0);

    cyc(5);
    chk(exp_q.size() == 0, "R3/R5 all expected requests seen", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule